// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block resolves a translation miss by reading page-table entries from memory one at a time until it reaches a final entry or something it cannot use. A miss request carries a 20-bit virtual page number (the upper 20 bits of a 32-bit virtual address), plus a context number. Alongside it comes a base pointer register that the walker samples when it accepts the request. Reads go out over a single-outstanding memory port with a valid/ready request side and a response valid strobe. The walk ends in a one-cycle `done` pulse. That pulse carries either a refill record for the translation buffer (physical page number, attribute bits, the level where the entry was found) or a fault cause for the access that missed.

A parameter picks the table format. In the two-level format, the base pointer is the root of the first-level table. In the three-level format, the base pointer addresses a context table. The walker first reads the entry selected by the request's context number, and that entry points to the first-level table. A final entry found above the deepest level maps a larger page, and the low bits of its physical page number then come from the virtual page number.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: The entry type sits in bits 1:0: 00 absent, 01 pointer (the next table base is the entry with bits 1:0 cleared), 10 final (PPN in bits 31:12, attributes in bits 11:2), 11 reserved. With THREE_LEVEL=0, the walker reads root+vpn[19:10]*4 and then next_base+vpn[9:0]*4. A final entry at step 2 returns entry bits 31:12 as the PPN.
- R3: With THREE_LEVEL=1, the walker reads root+ctx*4 (step 0) and then uses indices vpn[19:12], vpn[11:6] and vpn[5:0] (steps 1 to 3). Each read adds index*4 to the base taken from the previous pointer.
- R4: A final entry found before the deepest step ends the walk at once. The low PPN bits come from the VPN: 10 bits at step 1 in the two-level format, 12 bits at step 1 and 6 bits at step 2 in the three-level format.
- R5: A walk that faults reports `done_fault`=1 with `done_cause` 1 for an absent entry, 2 for a reserved type, and 3 for a misplaced entry (a pointer at the deepest step, or a final entry in the context table). On a fault, PPN and attributes are zero. `done_step` names the step that faulted (0 context, 1 to 3 table levels), and on success it names the step where the final entry was found.
- R6: At most one read is outstanding. A request waiting for `mem_req_ready` holds its address. Reads are issued in strict step order, one per visited step.
- R7: `done` is high for exactly one cycle, in the cycle after the last response, and `done_vpn` echoes the request.
- R8: The VPN, context and base pointer are sampled at acceptance, so later changes do not affect the walk in progress. A new request can be accepted in the same cycle in which `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle, request taken this cycle if valid |
| req_vpn | input | 20 | Virtual page number of the miss |
| req_ctx | input | CTX_W | Context number (three-level format) |
| root_base | input | 32 | Root table or context table byte address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion strobe |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 0 none, 1 absent, 2 reserved, 3 misplaced |
| done_step | output | 2 | Step where the walk ended |
| done_vpn | output | 20 | VPN of the completed request |
| done_ppn | output | 20 | Physical page number of the refill |
| done_attr | output | 10 | Attribute bits of the final entry |

## Verification
The completion pulse of one walk and the acceptance of the next request can fall in the same cycle, because the walker returns to idle as it raises `done`. The bench holds `req_valid` high with a second VPN for the whole of a first walk. It then judges that `done` and `req_ready` are both high on the same sample, that the first result still reflects the first VPN, and that the second walk completes with its own result. Read order and the one-outstanding rule are also checked with the memory model stalling its ready signal and adding response latency.

// File: rtl/xlate_walker.sv
module xlate_walker #(
  parameter bit THREE_LEVEL = 1'b1,
  parameter int CTX_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [19:0]      req_vpn,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic [31:0]      root_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [31:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             done,
  output logic             done_fault,
  output logic [1:0]       done_cause,
  output logic [1:0]       done_step,
  output logic [19:0]      done_vpn,
  output logic [19:0]      done_ppn,
  output logic [9:0]       done_attr
);
  localparam logic [1:0] FIRST_S = THREE_LEVEL ? 2'd0 : 2'd1;
  localparam logic [1:0] LAST_S  = THREE_LEVEL ? 2'd3 : 2'd2;

  typedef enum logic [1:0] {IDLE, ISSUE, AWAIT} st_t;
  st_t              st;
  logic [1:0]       step;
  logic [19:0]      vpn_q;
  logic [CTX_W-1:0] ctx_q;
  logic [31:0]      base_q;
  logic [9:0]       idx;
  logic [19:0]      low_mask;
  logic [1:0]       cause_n;
  logic             final_ok;

  always_comb begin
    idx      = '0;
    low_mask = '0;
    if (THREE_LEVEL) begin
      case (step)
        2'd0:    idx = 10'(ctx_q);
        2'd1:    begin idx = {2'b0, vpn_q[19:12]}; low_mask = 20'h00FFF; end
        2'd2:    begin idx = {4'b0, vpn_q[11:6]};  low_mask = 20'h0003F; end
        default: idx = {4'b0, vpn_q[5:0]};
      endcase
    end else begin
      case (step)
        2'd1:    begin idx = vpn_q[19:10]; low_mask = 20'h003FF; end
        default: idx = vpn_q[9:0];
      endcase
    end
  end

  always_comb begin
    cause_n = 2'd0;
    case (mem_rsp_data[1:0])
      2'b00: cause_n = 2'd1;
      2'b11: cause_n = 2'd2;
      2'b01: if (step == LAST_S) cause_n = 2'd3;
      default: if (step == 2'd0) cause_n = 2'd3;
    endcase
  end

  assign final_ok      = (mem_rsp_data[1:0] == 2'b10) && (cause_n == 2'd0);
  assign req_ready     = (st == IDLE);
  assign mem_req_valid = (st == ISSUE);
  assign mem_req_addr  = base_q + {20'b0, idx, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      step       <= 2'd0;
      vpn_q      <= '0;
      ctx_q      <= '0;
      base_q     <= '0;
      done       <= 1'b0;
      done_fault <= 1'b0;
      done_cause <= 2'd0;
      done_step  <= 2'd0;
      done_vpn   <= '0;
      done_ppn   <= '0;
      done_attr  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          vpn_q  <= req_vpn;
          ctx_q  <= req_ctx;
          base_q <= root_base;
          step   <= FIRST_S;
          st     <= ISSUE;
        end
        ISSUE: if (mem_req_ready) st <= AWAIT;
        AWAIT: if (mem_rsp_valid) begin
          if (final_ok || cause_n != 2'd0) begin
            done       <= 1'b1;
            done_fault <= (cause_n != 2'd0);
            done_cause <= cause_n;
            done_step  <= step;
            done_vpn   <= vpn_q;
            done_ppn   <= final_ok ? ((mem_rsp_data[31:12] & ~low_mask) | (vpn_q & low_mask)) : 20'd0;
            done_attr  <= final_ok ? mem_rsp_data[11:2] : 10'd0;
            st         <= IDLE;
          end else begin
            base_q <= {mem_rsp_data[31:2], 2'b00};
            step   <= step + 2'd1;
            st     <= ISSUE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic        done_fault,
  input logic [1:0]  done_cause,
  input logic [19:0] done_ppn,
  input logic [9:0]  done_attr
);
  a_r6_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r3_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rsp_valid));

  a_r5_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> (done_ppn == 20'd0 && done_attr == 10'd0));

  a_r5_cause_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_fault == (done_cause != 2'd0)));
endmodule

bind xlate_walker xlate_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .done(done),
  .done_fault(done_fault), .done_cause(done_cause), .done_ppn(done_ppn), .done_attr(done_attr)
);

// File: tb/xlate_walker_tb_top.sv
module xlate_walker_tb_mem (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);
  logic [31:0] a_tab [16];
  logic [31:0] d_tab [16];
  logic [31:0] rlog [64];
  logic [31:0] paddr;
  int n_used = 0;
  int lat = 0;
  bit stall = 0;
  bit tog;
  bit pend;
  int cnt;
  int nreads;
  int viol;

  assign req_ready = !stall || tog;

  function automatic logic [31:0] look(input logic [31:0] a);
    look = 32'h0;
    for (int i = 0; i < n_used; i++) if (a_tab[i] == a) look = d_tab[i];
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    a_tab[n_used] = a;
    d_tab[n_used] = d;
    n_used++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 0; rsp_valid <= 0; rsp_data <= 0; tog <= 0; nreads <= 0; viol <= 0; cnt <= 0; paddr <= 0;
    end else begin
      tog <= !tog;
      rsp_valid <= 0;
      if (req_valid && req_ready) begin
        if (pend) viol <= viol + 1;
        pend <= 1; paddr <= req_addr; cnt <= lat;
        rlog[nreads[5:0]] <= req_addr;
        nreads <= nreads + 1;
      end else if (pend) begin
        if (cnt == 0) begin rsp_valid <= 1; rsp_data <= look(paddr); pend <= 0; end
        else cnt <= cnt - 1;
      end
    end
  end
endmodule

module xlate_walker_tb_top;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic        sel;
    logic [7:0]  ctx;
    logic [19:0] vpn;
    logic        flt;
    logic [1:0]  cause;
    logic [1:0]  step;
    logic [19:0] ppn;
    logic [9:0]  attr;
    logic [2:0]  nrd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0, 20'h00405, 1'b0, 2'd0, 2'd2, 20'hABCDE, 10'h003, 3'd2},
    '{1'b0, 8'd0, 20'h00AAB, 1'b0, 2'd0, 2'd1, 20'h556AB, 10'h002, 3'd1},
    '{1'b0, 8'd0, 20'h00406, 1'b1, 2'd1, 2'd2, 20'h00000, 10'h000, 3'd2},
    '{1'b0, 8'd0, 20'h00407, 1'b1, 2'd2, 2'd2, 20'h00000, 10'h000, 3'd2},
    '{1'b0, 8'd0, 20'h00408, 1'b1, 2'd3, 2'd2, 20'h00000, 10'h000, 3'd2},
    '{1'b0, 8'd0, 20'h00C00, 1'b1, 2'd1, 2'd1, 20'h00000, 10'h000, 3'd1},
    '{1'b0, 8'd0, 20'h01000, 1'b1, 2'd2, 2'd1, 20'h00000, 10'h000, 3'd1},
    '{1'b1, 8'd3, 20'h12149, 1'b0, 2'd0, 2'd3, 20'hCAFEB, 10'h003, 3'd4},
    '{1'b1, 8'd3, 20'h139A5, 1'b0, 2'd0, 2'd1, 20'h779A5, 10'h001, 3'd2},
    '{1'b1, 8'd3, 20'h121AD, 1'b0, 2'd0, 2'd2, 20'h888AD, 10'h000, 3'd3},
    '{1'b1, 8'd3, 20'h1214A, 1'b1, 2'd3, 2'd3, 20'h00000, 10'h000, 3'd4},
    '{1'b1, 8'd3, 20'h1214B, 1'b1, 2'd1, 2'd3, 20'h00000, 10'h000, 3'd4},
    '{1'b1, 8'd5, 20'h00000, 1'b1, 2'd3, 2'd0, 20'h00000, 10'h000, 3'd1},
    '{1'b1, 8'd7, 20'h00000, 1'b1, 2'd1, 2'd0, 20'h00000, 10'h000, 3'd1}
  };

  logic clk = 0;
  logic rst_n = 0;
  always #(CLK_NS/2) clk = ~clk;

  logic a_req_valid = 0, b_req_valid = 0;
  logic [19:0] a_req_vpn = 0, b_req_vpn = 0;
  logic [7:0]  a_req_ctx = 0, b_req_ctx = 0;
  logic [31:0] a_root = 32'h0001_0000, b_root = 32'h0004_0000;
  logic a_req_ready, b_req_ready, a_mv, b_mv, a_mr, b_mr, a_rv, b_rv;
  logic [31:0] a_ma, b_ma, a_rd, b_rd;
  logic a_done, b_done, a_flt, b_flt;
  logic [1:0] a_cause, b_cause, a_step, b_step;
  logic [19:0] a_vpn, b_vpn, a_ppn, b_ppn;
  logic [9:0] a_attr, b_attr;

  xlate_walker #(.THREE_LEVEL(1'b0), .CTX_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(a_req_valid), .req_ready(a_req_ready),
    .req_vpn(a_req_vpn), .req_ctx(a_req_ctx), .root_base(a_root),
    .mem_req_valid(a_mv), .mem_req_ready(a_mr), .mem_req_addr(a_ma),
    .mem_rsp_valid(a_rv), .mem_rsp_data(a_rd), .done(a_done), .done_fault(a_flt),
    .done_cause(a_cause), .done_step(a_step), .done_vpn(a_vpn), .done_ppn(a_ppn), .done_attr(a_attr));

  xlate_walker #(.THREE_LEVEL(1'b1), .CTX_W(8)) dut3_i (
    .clk(clk), .rst_n(rst_n), .req_valid(b_req_valid), .req_ready(b_req_ready),
    .req_vpn(b_req_vpn), .req_ctx(b_req_ctx), .root_base(b_root),
    .mem_req_valid(b_mv), .mem_req_ready(b_mr), .mem_req_addr(b_ma),
    .mem_rsp_valid(b_rv), .mem_rsp_data(b_rd), .done(b_done), .done_fault(b_flt),
    .done_cause(b_cause), .done_step(b_step), .done_vpn(b_vpn), .done_ppn(b_ppn), .done_attr(b_attr));

  xlate_walker_tb_mem mem_a (.clk(clk), .rst_n(rst_n), .req_valid(a_mv), .req_addr(a_ma),
    .req_ready(a_mr), .rsp_valid(a_rv), .rsp_data(a_rd));
  xlate_walker_tb_mem mem_b (.clk(clk), .rst_n(rst_n), .req_valid(b_mv), .req_addr(b_ma),
    .req_ready(b_mr), .rsp_valid(b_rv), .rsp_data(b_rd));

  logic cur = 0;
  wire        o_ready = cur ? b_req_ready : a_req_ready;
  wire        o_done  = cur ? b_done  : a_done;
  wire        o_flt   = cur ? b_flt   : a_flt;
  wire [1:0]  o_cause = cur ? b_cause : a_cause;
  wire [1:0]  o_step  = cur ? b_step  : a_step;
  wire [19:0] o_vpn   = cur ? b_vpn   : a_vpn;
  wire [19:0] o_ppn   = cur ? b_ppn   : a_ppn;
  wire [9:0]  o_attr  = cur ? b_attr  : a_attr;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic launch(input logic s, input logic [7:0] ctx, input logic [19:0] vpn);
    @(negedge clk);
    cur = s;
    if (s) begin b_req_valid = 1; b_req_vpn = vpn; b_req_ctx = ctx; end
    else   begin a_req_valid = 1; a_req_vpn = vpn; end
    while (!o_ready) @(negedge clk);
    @(negedge clk);
    a_req_valid = 0;
    b_req_valid = 0;
  endtask

  task automatic wait_done(input string tag);
    int i;
    for (i = 0; i < 400; i++) begin
      if (o_done) break;
      @(negedge clk);
    end
    chk(tag, "done seen", 32'(o_done), 32'd1);
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    int n0;
    if (v.flt) tag = "R5";
    else if (!v.sel && v.step == 2'd2) tag = "R2";
    else if (v.sel && v.step == 2'd3) tag = "R3";
    else tag = "R4";
    n0 = v.sel ? mem_b.nreads : mem_a.nreads;
    launch(v.sel, v.ctx, v.vpn);
    wait_done(tag);
    chk(tag, "fault", 32'(o_flt), 32'(v.flt));
    chk(tag, "cause", 32'(o_cause), 32'(v.cause));
    chk(tag, "step", 32'(o_step), 32'(v.step));
    chk(tag, "ppn", 32'(o_ppn), 32'(v.ppn));
    chk(tag, "attr", 32'(o_attr), 32'(v.attr));
    chk("R7", "vpn echo", 32'(o_vpn), 32'(v.vpn));
    chk("R6", "read count", 32'((v.sel ? mem_b.nreads : mem_a.nreads) - n0), 32'(v.nrd));
    @(negedge clk);
    chk("R7", "done one cycle", 32'(o_done), 32'd0);
  endtask

  initial begin
    int n0;
    mem_a.put(32'h0001_0004, 32'h0002_0001);
    mem_a.put(32'h0001_0008, 32'h5550_000A);
    mem_a.put(32'h0001_0010, 32'h0000_0003);
    mem_a.put(32'h0002_0014, 32'hABCD_E00E);
    mem_a.put(32'h0002_001C, 32'h1234_5003);
    mem_a.put(32'h0002_0020, 32'h0003_0001);
    mem_b.put(32'h0004_000C, 32'h0005_0001);
    mem_b.put(32'h0004_0014, 32'h0000_0002);
    mem_b.put(32'h0005_0048, 32'h0006_0001);
    mem_b.put(32'h0005_004C, 32'h7700_0006);
    mem_b.put(32'h0006_0014, 32'h0007_0001);
    mem_b.put(32'h0006_0018, 32'h8888_8002);
    mem_b.put(32'h0007_0024, 32'hCAFE_B00E);
    mem_b.put(32'h0007_0028, 32'h0000_0001);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready 2L", 32'(a_req_ready), 32'd1);
    chk("R1", "done 2L", 32'(a_done), 32'd0);
    chk("R1", "memreq 2L", 32'(a_mv), 32'd0);
    chk("R1", "ready 3L", 32'(b_req_ready), 32'd1);
    chk("R1", "done 3L", 32'(b_done), 32'd0);
    chk("R1", "memreq 3L", 32'(b_mv), 32'd0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R6 / R3: read order under stalls and latency, three-level full walk
    mem_b.stall = 1; mem_b.lat = 3;
    n0 = mem_b.nreads;
    run_vec(VECS[7]);
    chk("R3", "read0", mem_b.rlog[(n0 + 0) % 64], 32'h0004_000C);
    chk("R3", "read1", mem_b.rlog[(n0 + 1) % 64], 32'h0005_0048);
    chk("R3", "read2", mem_b.rlog[(n0 + 2) % 64], 32'h0006_0014);
    chk("R3", "read3", mem_b.rlog[(n0 + 3) % 64], 32'h0007_0024);
    chk("R6", "single outstanding 3L", 32'(mem_b.viol), 32'd0);
    mem_b.stall = 0; mem_b.lat = 0;

    // R2 / R6: two-level order under stalls
    mem_a.stall = 1; mem_a.lat = 2;
    n0 = mem_a.nreads;
    run_vec(VECS[0]);
    chk("R2", "read0", mem_a.rlog[(n0 + 0) % 64], 32'h0001_0004);
    chk("R2", "read1", mem_a.rlog[(n0 + 1) % 64], 32'h0002_0014);
    chk("R6", "single outstanding 2L", 32'(mem_a.viol), 32'd0);
    mem_a.stall = 0; mem_a.lat = 0;

    // R8: inputs changed mid-walk ignored; next request taken in the done cycle
    @(negedge clk);
    cur = 0;
    a_req_valid = 1; a_req_vpn = 20'h00405;
    @(negedge clk);
    a_req_vpn = 20'h00AAB;
    a_root = 32'h0001_0000;
    wait_done("R8");
    chk("R8", "first ppn", 32'(a_ppn), 32'hABCDE);
    chk("R8", "first vpn", 32'(a_vpn), 32'h00405);
    chk("R8", "ready with done", 32'(a_req_ready), 32'd1);
    @(negedge clk);
    a_req_valid = 0;
    chk("R8", "second accepted", 32'(a_req_ready), 32'd0);
    chk("R7", "pulse width", 32'(a_done), 32'd0);
    wait_done("R8");
    chk("R8", "second ppn", 32'(a_ppn), 32'h556AB);
    chk("R8", "second step", 32'(a_step), 32'd1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule